// File: doc/BRIEF.md
# Extended-Precision Value Classifier and Tag Encoder

This block sorts 80-bit extended-precision values (one sign bit, a 15-bit biased exponent, and a 64-bit significand whose top bit is an explicit integer bit) into classes, and turns those classes into the encodings a floating-point register stack keeps. It has three parts:

- An examine path. It takes the value at the stack top and a 16-bit status word. It returns the status word with the four condition-code bits rewritten to describe the value.
- A builder. It walks the eight register slots one per clock and assembles the 16-bit full tag word, two bits per slot.
- A converter. It turns a full tag word into per-slot empty flags, and turns empty flags into the 8-bit short tag byte and back.

The register file stays outside. The builder puts out a slot index, and the surrounding logic returns that slot's 80-bit contents on the same cycle. The empty flags for all eight slots arrive on a single 8-bit input. The examine path and the converter are purely combinational. Only the builder takes time: eight cycles after an accepted start.

Top module: `fpx_tag_unit`

## Requirements
- R1: The examine output equals the status input with bits 14 (C3), 10 (C2), 9 (C1) and 8 (C0) first cleared. C1 is then set to the value's sign bit (bit 79). Every other status bit passes through unchanged.
- R2: With exponent (bits 78:64) all ones and significand (bits 63:0) exactly 0x8000_0000_0000_0000, examine sets C2 and C0. With all-ones exponent and any other significand, it sets C0 alone.
- R3: With exponent zero and significand zero, examine sets C3 alone. With exponent zero and a nonzero significand, it sets C3 and C2.
- R4: Any other value sets C2 alone, including one whose significand bit 63 is clear.
- R5: The tag code of a slot is decided in this order:
  - 11 if the slot's empty flag is set, whatever its contents;
  - otherwise 01 for exponent and significand both zero;
  - otherwise 10 when the exponent is zero or all ones, or significand bit 63 is clear;
  - otherwise 00.
- R6: The full tag word holds slot i's code in bits [2i+1:2i]. During a build, the slot index output visits slots 7, 6, …, 0, one per cycle, starting the cycle after the start is accepted.
- R7: A build raises busy for exactly eight cycles. On the eighth edge after the accepting edge, busy falls and done is high for exactly one cycle. The tag word then holds its value until the next accepted start.
- R8: A start pulse that arrives while busy is high is ignored. The index sequence and the result are unaffected.
- R9: Parsing a full tag word sets empty flag i exactly when bits [2i+1:2i] equal 11.
- R10: Short tag byte bit i is the inverse of empty flag i. The reverse conversion gives empty flag i as the inverse of byte bit i.
- R11: After reset: busy and done are low, the tag word is zero, and the slot index is 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exam_value | input | 80 | Value to examine (stack top) |
| exam_status_in | input | 16 | Status word before examine |
| exam_status_out | output | 16 | Status word with rewritten condition codes |
| build_start | input | 1 | Request a full tag word build |
| slot_empty | input | 8 | Empty flag of each physical slot |
| slot_idx | output | 3 | Slot whose contents are requested |
| slot_data | input | 80 | Contents of slot `slot_idx` |
| build_busy | output | 1 | Build in progress |
| build_done | output | 1 | One-cycle pulse when the tag word is complete |
| tag_word | output | 16 | Assembled full tag word |
| parse_word | input | 16 | Full tag word to parse |
| parse_empty | output | 8 | Empty flags decoded from `parse_word` |
| short_empty_in | input | 8 | Empty flags to compress |
| short_tag_out | output | 8 | Short tag byte from `short_empty_in` |
| short_tag_in | input | 8 | Short tag byte to expand |
| short_empty_out | output | 8 | Empty flags from `short_tag_in` |

## Verification
The examine path is swept over every combination of boundary exponents and boundary significands, with both signs, against three status backgrounds:
- The exponents are 0, 1, mid-range, 0x7FFE and 0x7FFF.
- The significands are zero, the lone integer bit, one, integer bit clear with upper bits set, and all ones.
- These separate infinity from NaN, zero from denormal, and an unnormal from a true normal, and the backgrounds show that untouched status bits pass through.

Builds run over many slot mixes, each containing empty, zero, special and valid entries. Every slot position takes every class at some point, so a swapped field order or a wrong precedence changes the word. One build injects a start mid-scan to prove it is ignored.

The parse and short-tag conversions are swept exhaustively over all inputs.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int EXP_W = 15;
  localparam int SIG_W = 64;
  localparam int VAL_W = 1 + EXP_W + SIG_W;
  localparam int STAT_W = 16;

  // condition-code positions inside the status word
  localparam int CC0_POS = 8;
  localparam int CC1_POS = 9;
  localparam int CC2_POS = 10;
  localparam int CC3_POS = 14;

  localparam logic [EXP_W-1:0] EXP_TOP = '1;
  localparam logic [SIG_W-1:0] SIG_INT_ONLY = {1'b1, {(SIG_W-1){1'b0}}};

  typedef struct packed {
    logic             sign;
    logic [EXP_W-1:0] exp;
    logic [SIG_W-1:0] sig;
  } fpx_t;

  typedef enum logic [1:0] {
    TAG_VALID   = 2'b00,
    TAG_ZERO    = 2'b01,
    TAG_SPECIAL = 2'b10,
    TAG_EMPTY   = 2'b11
  } tag_e;

  typedef struct packed {
    logic c3;
    logic c2;
    logic c1;
    logic c0;
  } cc_t;

  // condition codes produced by examine
  function automatic cc_t exam_codes(fpx_t v);
    cc_t cc;
    cc = '0;
    cc.c1 = v.sign;
    if (v.exp == EXP_TOP) begin
      cc.c0 = 1'b1;
      cc.c2 = (v.sig == SIG_INT_ONLY);
    end else if (v.exp == '0) begin
      cc.c3 = 1'b1;
      cc.c2 = (v.sig != '0);
    end else begin
      cc.c2 = 1'b1;
    end
    return cc;
  endfunction

  // clear the four codes, then insert the new ones
  function automatic logic [STAT_W-1:0] merge_status(logic [STAT_W-1:0] s, cc_t cc);
    logic [STAT_W-1:0] r;
    r = s;
    r[CC3_POS] = cc.c3;
    r[CC2_POS] = cc.c2;
    r[CC1_POS] = cc.c1;
    r[CC0_POS] = cc.c0;
    return r;
  endfunction

  // two-bit tag for one slot
  function automatic tag_e tag_code(fpx_t v, logic empty);
    if (empty)
      return TAG_EMPTY;
    if (v.exp == '0 && v.sig == '0)
      return TAG_ZERO;
    if (v.exp == '0 || v.exp == EXP_TOP || !v.sig[SIG_W-1])
      return TAG_SPECIAL;
    return TAG_VALID;
  endfunction
endpackage

// File: rtl/fpx_examine.sv
module fpx_examine
  import fpx_pkg::*;
(
  input  logic [VAL_W-1:0]  value,
  input  logic [STAT_W-1:0] status_in,
  output logic [STAT_W-1:0] status_out
);
  localparam logic [STAT_W-1:0] CC_MASK =
    STAT_W'((1 << CC3_POS) | (1 << CC2_POS) | (1 << CC1_POS) | (1 << CC0_POS));

  fpx_t v;
  cc_t  cc;
  logic top_exp;

  assign v          = fpx_t'(value);
  assign cc         = exam_codes(v);
  assign top_exp    = (v.exp == EXP_TOP);
  assign status_out = merge_status(status_in, cc);

  always_comb begin
    if (!$isunknown({value, status_in})) begin
      a_r1_sign_copied: assert (status_out[CC1_POS] == value[VAL_W-1]);
      a_r1_others_kept: assert ((status_out & ~CC_MASK) == (status_in & ~CC_MASK));
      a_r2_top_exp_c0: assert (!top_exp || (status_out[CC0_POS] && !status_out[CC3_POS]));
      a_r3_zero_exp_c3: assert ((v.exp != '0) || (status_out[CC3_POS] && !status_out[CC0_POS]));
    end
  end
endmodule

// File: rtl/fpx_tag_builder.sv
module fpx_tag_builder
  import fpx_pkg::*;
#(
  parameter int NSLOTS = 8,
  parameter int IDX_W  = $clog2(NSLOTS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [NSLOTS-1:0]     empty_in,
  input  logic [VAL_W-1:0]      slot_data,
  output logic [IDX_W-1:0]      slot_idx,
  output logic                  busy,
  output logic                  done,
  output logic [2*NSLOTS-1:0]   tag_word
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NSLOTS - 1);
  localparam int               TW     = 2 * NSLOTS;

  logic             busy_q, done_q;
  logic [IDX_W-1:0] idx_q;
  logic [TW-1:0]    acc_q;

  // named internal events
  logic start_accept, last_step;
  tag_e cur_code;

  assign start_accept = start && !busy_q;
  assign last_step    = busy_q && (idx_q == '0);
  assign cur_code     = tag_code(fpx_t'(slot_data), empty_in[idx_q]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= LAST_IDX;
      acc_q  <= '0;
    end else begin
      done_q <= last_step;
      if (start_accept) begin
        busy_q <= 1'b1;
        idx_q  <= LAST_IDX;
        acc_q  <= '0;
      end else if (busy_q) begin
        acc_q <= {acc_q[TW-3:0], cur_code};
        if (last_step) begin
          busy_q <= 1'b0;
          idx_q  <= LAST_IDX;
        end else begin
          idx_q <= idx_q - 1'b1;
        end
      end
    end
  end

  assign slot_idx = idx_q;
  assign busy     = busy_q;
  assign done     = done_q;
  assign tag_word = acc_q;

  // step counter used only by the checks below
  logic [IDX_W:0] steps_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      steps_q <= '0;
    else if (start_accept)
      steps_q <= '0;
    else if (busy_q)
      steps_q <= steps_q + 1'b1;
  end

  a_r6_index_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && idx_q != '0) |=> (busy_q && idx_q == $past(idx_q) - 1'b1));
  a_r7_done_after_eight: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (steps_q == (IDX_W+1)'(NSLOTS)));
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  a_r7_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start) |=> $stable(acc_q));
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start && idx_q != '0) |=> (idx_q != LAST_IDX));
endmodule

// File: rtl/fpx_tag_convert.sv
module fpx_tag_convert #(
  parameter int NSLOTS = 8
) (
  input  logic [2*NSLOTS-1:0] word_in,
  output logic [NSLOTS-1:0]   word_empty,
  input  logic [NSLOTS-1:0]   empty_in,
  output logic [NSLOTS-1:0]   short_out,
  input  logic [NSLOTS-1:0]   short_in,
  output logic [NSLOTS-1:0]   short_empty
);
  for (genvar i = 0; i < NSLOTS; i++) begin : g_slot
    assign word_empty[i]  = (word_in[2*i+1 -: 2] == 2'b11);
    assign short_out[i]   = ~empty_in[i];
    assign short_empty[i] = ~short_in[i];
  end

  always_comb begin
    if (!$isunknown({empty_in, short_in}) && short_in == short_out) begin
      a_r10_round_trip: assert (short_empty == empty_in);
    end
    if (!$isunknown(word_in) && word_in == '1) begin
      a_r9_all_empty: assert (word_empty == '1);
    end
  end
endmodule

// File: rtl/fpx_tag_unit.sv
module fpx_tag_unit
  import fpx_pkg::*;
#(
  parameter int NSLOTS = 8,
  parameter int IDX_W  = $clog2(NSLOTS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [VAL_W-1:0]    exam_value,
  input  logic [STAT_W-1:0]   exam_status_in,
  output logic [STAT_W-1:0]   exam_status_out,
  input  logic                build_start,
  input  logic [NSLOTS-1:0]   slot_empty,
  output logic [IDX_W-1:0]    slot_idx,
  input  logic [VAL_W-1:0]    slot_data,
  output logic                build_busy,
  output logic                build_done,
  output logic [2*NSLOTS-1:0] tag_word,
  input  logic [2*NSLOTS-1:0] parse_word,
  output logic [NSLOTS-1:0]   parse_empty,
  input  logic [NSLOTS-1:0]   short_empty_in,
  output logic [NSLOTS-1:0]   short_tag_out,
  input  logic [NSLOTS-1:0]   short_tag_in,
  output logic [NSLOTS-1:0]   short_empty_out
);
  fpx_examine u_examine (
    .value      (exam_value),
    .status_in  (exam_status_in),
    .status_out (exam_status_out)
  );

  fpx_tag_builder #(.NSLOTS(NSLOTS), .IDX_W(IDX_W)) u_builder (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (build_start),
    .empty_in  (slot_empty),
    .slot_data (slot_data),
    .slot_idx  (slot_idx),
    .busy      (build_busy),
    .done      (build_done),
    .tag_word  (tag_word)
  );

  fpx_tag_convert #(.NSLOTS(NSLOTS)) u_convert (
    .word_in     (parse_word),
    .word_empty  (parse_empty),
    .empty_in    (short_empty_in),
    .short_out   (short_tag_out),
    .short_in    (short_tag_in),
    .short_empty (short_empty_out)
  );
endmodule

// File: tb/test_fpx_tag_unit.sv
module test_fpx_tag_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [79:0] exam_value = '0;
  logic [15:0] exam_status_in = '0;
  logic [15:0] exam_status_out;
  logic        build_start = 1'b0;
  logic [7:0]  slot_empty = '0;
  logic [2:0]  slot_idx;
  logic [79:0] slot_data;
  logic        build_busy, build_done;
  logic [15:0] tag_word;
  logic [15:0] parse_word = '0;
  logic [7:0]  parse_empty;
  logic [7:0]  short_empty_in = '0;
  logic [7:0]  short_tag_out;
  logic [7:0]  short_tag_in = '0;
  logic [7:0]  short_empty_out;

  logic [79:0] slot_mem [8];
  assign slot_data = slot_mem[slot_idx];

  always #10 clk = ~clk;

  fpx_tag_unit i_fpx_tag_unit (
    .clk(clk), .rst_n(rst_n),
    .exam_value(exam_value), .exam_status_in(exam_status_in),
    .exam_status_out(exam_status_out),
    .build_start(build_start), .slot_empty(slot_empty), .slot_idx(slot_idx),
    .slot_data(slot_data), .build_busy(build_busy), .build_done(build_done),
    .tag_word(tag_word), .parse_word(parse_word), .parse_empty(parse_empty),
    .short_empty_in(short_empty_in), .short_tag_out(short_tag_out),
    .short_tag_in(short_tag_in), .short_empty_out(short_empty_out)
  );

  int total = 0;
  int fails = 0;
  bit finished = 0;

  task automatic check(bit ok, string req, string what, logic [79:0] act, logic [79:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [79:0] mk(bit s, logic [14:0] e, logic [63:0] m);
    return {s, e, m};
  endfunction

  // expected examine result built from bit positions 14,10,9,8
  function automatic logic [15:0] exp_exam(logic [79:0] v, logic [15:0] st);
    logic [15:0] r;
    logic [14:0] e;
    logic [63:0] m;
    e = v[78:64];
    m = v[63:0];
    r = st & 16'hB8FF;
    if (v[79]) r = r | 16'h0200;
    if (e == 15'h7FFF)
      r = r | ((m == 64'h8000_0000_0000_0000) ? 16'h0500 : 16'h0100);
    else if (e == 0)
      r = r | ((m == 0) ? 16'h4000 : 16'h4400);
    else
      r = r | 16'h0400;
    return r;
  endfunction

  function automatic logic [1:0] exp_tag(logic [79:0] v, bit empty);
    if (empty) return 2'd3;
    if (v[78:64] == 0 && v[63:0] == 0) return 2'd1;
    if (v[78:64] == 0 || v[78:64] == 15'h7FFF || v[63] == 1'b0) return 2'd2;
    return 2'd0;
  endfunction

  logic [79:0] tv [10];

  task automatic run_build(bit inject, string tagname);
    logic [15:0] want;
    want = '0;
    for (int i = 0; i < 8; i++) want[2*i +: 2] = exp_tag(slot_mem[i], slot_empty[i]);
    @(negedge clk);
    build_start = 1'b1;
    @(posedge clk);
    #1 build_start = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check(slot_idx == 3'(7 - k) && build_busy && !build_done, "R6",
            {tagname, " index/busy during scan"}, {76'd0, build_busy, slot_idx}, {77'd1, 3'(7 - k)});
      build_start = (inject && k == 3);
    end
    build_start = 1'b0;
    @(negedge clk);
    check(build_done && !build_busy, "R7", {tagname, " done after eight"},
          {78'd0, build_done, build_busy}, 80'd2);
    check(tag_word == want, inject ? "R8" : "R5", {tagname, " tag word"}, {64'd0, tag_word}, {64'd0, want});
    @(negedge clk);
    check(!build_done && tag_word == want, "R7", {tagname, " done single, word held"},
          {63'd0, build_done, tag_word}, {64'd0, want});
  endtask

  initial begin
    logic [14:0] exps [5];
    logic [63:0] sigs [5];
    logic [15:0] bgs  [3];
    exps = '{15'h0000, 15'h0001, 15'h3FFF, 15'h7FFE, 15'h7FFF};
    sigs = '{64'h0, 64'h8000_0000_0000_0000, 64'h1, 64'h7FFF_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF};
    bgs  = '{16'h0000, 16'hFFFF, 16'hA5C3};
    for (int i = 0; i < 8; i++) slot_mem[i] = '0;
    tv[0] = mk(0, 15'h0000, 64'h0);                   // zero
    tv[1] = mk(1, 15'h3FFF, 64'h8000_0000_0000_0000); // valid
    tv[2] = mk(0, 15'h7FFF, 64'h8000_0000_0000_0000); // inf
    tv[3] = mk(0, 15'h7FFF, 64'hC000_0000_0000_0001); // nan
    tv[4] = mk(0, 15'h0000, 64'h0000_0000_0000_0001); // denormal
    tv[5] = mk(1, 15'h4005, 64'h7FFF_FFFF_FFFF_FFFF); // unnormal
    tv[6] = mk(0, 15'h7FFE, 64'hFFFF_FFFF_FFFF_FFFF); // valid
    tv[7] = mk(1, 15'h0000, 64'h0);                   // negative zero
    tv[8] = mk(0, 15'h0001, 64'h8000_0000_0000_0000); // valid
    tv[9] = mk(1, 15'h1234, 64'h0);                   // unnormal zero sig

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(!build_busy && !build_done && tag_word == 0 && slot_idx == 3'd7, "R11", "reset state",
          {58'd0, build_busy, build_done, tag_word, 1'b0, slot_idx}, {74'd0, 3'd0, 3'd7});

    // examine sweep: R1 R2 R3 R4
    for (int e = 0; e < 5; e++)
      for (int m = 0; m < 5; m++)
        for (int s = 0; s < 2; s++)
          for (int b = 0; b < 3; b++) begin
            string rq;
            exam_value = mk(s[0], exps[e], sigs[m]);
            exam_status_in = bgs[b];
            #1;
            if (exps[e] == 15'h7FFF) rq = "R2";
            else if (exps[e] == 0) rq = "R3";
            else rq = "R4";
            check(exam_status_out == exp_exam(exam_value, exam_status_in), rq, "examine codes",
                  {64'd0, exam_status_out}, {64'd0, exp_exam(exam_value, exam_status_in)});
            check(exam_status_out[9] == s[0] &&
                  (exam_status_out & 16'hB8FF) == (exam_status_in & 16'hB8FF), "R1", "sign and passthrough",
                  {64'd0, exam_status_out}, {64'd0, exp_exam(exam_value, exam_status_in)});
          end

    // builds over varied slot mixes: R5 R6 R7
    for (int p = 0; p < 20; p++) begin
      for (int i = 0; i < 8; i++) slot_mem[i] = tv[(p * 3 + i * 7) % 10];
      slot_empty = 8'((p * 37 + 11) & 8'hFF) ^ 8'(p[0] ? 8'h0F : 8'hA0);
      run_build(1'b0, "mix");
    end
    // all empty, none empty
    slot_empty = 8'hFF;
    run_build(1'b0, "all-empty");
    for (int i = 0; i < 8; i++) slot_mem[i] = tv[i];
    slot_empty = 8'h00;
    run_build(1'b0, "none-empty");
    // R8 start injected mid-scan
    slot_empty = 8'h21;
    run_build(1'b1, "restart-ignored");

    // R9 parse sweep
    for (int w = 0; w < 65536; w++) begin
      logic [7:0] want;
      parse_word = 16'(w);
      for (int i = 0; i < 8; i++) want[i] = (((w >> (2 * i)) & 3) == 3);
      #1;
      check(parse_empty == want, "R9", "parse empty flags", {72'd0, parse_empty}, {72'd0, want});
    end

    // R10 short tag both directions
    for (int v = 0; v < 256; v++) begin
      short_empty_in = 8'(v);
      short_tag_in = 8'(v);
      #1;
      check(short_tag_out == 8'(255 - v), "R10", "short from empty", {72'd0, short_tag_out}, {72'd0, 8'(255 - v)});
      check(short_empty_out == 8'(255 - v), "R10", "empty from short", {72'd0, short_empty_out}, {72'd0, 8'(255 - v)});
    end

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule